// File: doc/BRIEF.md
# 16-bit Timer/Counter with Capture and Reload

This block is a 16-bit up/down counter with a companion 16-bit holding pair. A free-running prescaler splits the clock into machine cycles of twelve clocks. The counter advances either once per machine cycle (timer source) or once per falling edge on an external count pin (event source). Both external pins are sampled once per machine cycle, at the end of it, and an edge is a high sample followed by a low sample.

The holding pair plays a different role in each of three operating styles. In capture style, an edge on the trigger pin freezes the running count into the pair. In reload style, the pair is the value the counter restarts from: it counts up and restarts from the pair after 0xFFFF, or it counts down and jumps to 0xFFFF after reaching the pair. In baud style, the counter reloads from the pair on every wrap and emits a one-clock tick instead of raising the overflow flag, so the pair sets the tick period. Software programs the block through a small byte-wide write port. The count, the pair and both configuration registers are visible on output ports.

Top module: `tc16_capreload`

## Requirements
- R1: While reset is low, count, pair, control register, mode register, both flags and the tick are all zero.
- R2: With the timer source selected (control bit 1 = 0) and run set (control bit 0 = 1), the count rises by exactly one every 12 clocks, and it never changes on a clock that does not end a machine cycle.
- R3: With the event source selected (control bit 1 = 1), the count rises by one for each machine cycle whose count-pin sample is low when the previous sample was high. A pin held steady leaves the count unchanged.
- R4: With run clear, the count holds its value, except for register writes and reload-style triggers.
- R5: In capture style (control bits 4:3 = 00), a trigger edge with trigger-enable set (control bit 2 = 1) copies the count as it was before that cycle's step into the pair and sets the external flag (control bit 6).
- R6: With trigger-enable clear, a trigger edge changes neither the pair nor the external flag.
- R7: In capture style, a step from 0xFFFF gives 0x0000 and sets the overflow flag (control bit 7).
- R8: In reload style (bits 4:3 = 01) counting up (mode bit 0 = 0), a step from 0xFFFF loads the pair and sets the overflow flag.
- R9: In reload style counting down (mode bit 0 = 1), the count falls by one per step. A step taken while the count equals the pair loads 0xFFFF and sets the overflow flag.
- R10: In reload style, an enabled trigger edge loads the pair into the count, takes the place of that cycle's step, and sets the external flag.
- R11: In baud style (bits 4:3 = 10), a step from 0xFFFF loads the pair and raises the tick for exactly one clock. The overflow flag is never set in this style.
- R12: Writing the control register writes both flags, so a 0 clears a flag. When hardware sets a flag in the same clock as a software write, the flag ends up set.
- R13: Register addresses: 0 control, 1 mode, 2 count low byte, 3 count high byte, 4 pair low byte, 5 pair high byte. Written values read back on the control and mode outputs, and only mode bit 0 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_pin | input | 1 | External count input (event source) |
| trig_pin | input | 1 | External capture/reload trigger input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| count | output | 16 | Current counter value |
| cap | output | 16 | Capture/reload pair |
| ctrl_q | output | 8 | Control register |
| mode_q | output | 8 | Mode register |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External trigger flag |
| baud_tick | output | 1 | One-clock baud tick |

## Verification
Two things can land on the same clock: a hardware flag set, caused by the counter wrapping at the end of a machine cycle, and a software write to the control register that clears that flag. The bench tracks the machine-cycle phase by counting clocks from reset, so it can place a control write carrying a 0 in the overflow bit exactly on the clock where the count wraps from 0xFFFF. It then expects the flag to be set and the count to be 0x0000. A second pairing is a trigger and a step in the same machine cycle. In capture style the pair must hold the value from before the step. In reload style the reload must win and the step must be lost.

// File: rtl/tc16_pkg.sv
package tc16_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd5;

  localparam int CB_RUN  = 0;
  localparam int CB_SRC  = 1;
  localparam int CB_TEN  = 2;
  localparam int CB_MODE = 3;
  localparam int CB_EXT  = 6;
  localparam int CB_OVF  = 7;
  localparam int MB_DOWN = 0;

  typedef enum logic [1:0] {
    TM_CAPTURE = 2'd0,
    TM_RELOAD  = 2'd1,
    TM_BAUD    = 2'd2,
    TM_SPARE   = 2'd3
  } tc_mode_e;
endpackage

// File: rtl/tc16_cycle_gen.sv
module tc16_cycle_gen #(
  parameter int CYC_LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic mc_en
);
  localparam int PW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

  logic [PW-1:0] phase_q;

  assign mc_en = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (mc_en) phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tc16_fall_sampler.sv
module tc16_fall_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_en,
  input  logic pin,
  output logic fall
);
  logic last_q;

  assign fall = mc_en & last_q & ~pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= 1'b0;
    else if (mc_en) last_q <= pin;
  end
endmodule

// File: rtl/tc16_count_core.sv
module tc16_count_core
  import tc16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  trig,
  input  tc_mode_e              mode,
  input  logic                  down,
  input  logic                  wr_cnt_lo,
  input  logic                  wr_cnt_hi,
  input  logic                  wr_cap_lo,
  input  logic                  wr_cap_hi,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [2*BYTE_W-1:0]   count,
  output logic [2*BYTE_W-1:0]   cap,
  output logic                  ovf_set,
  output logic                  ext_set,
  output logic                  tick
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  // carry out in the top bit
  function automatic logic [CNT_W:0] f_up(input logic [CNT_W-1:0] v);
    return {1'b0, v} + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] f_down(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q, cap_q, cnt_nxt, cap_nxt;
  logic             tick_q, tick_nxt;
  logic [CNT_W:0]   up_v;
  logic             reload_trig;

  assign up_v        = f_up(cnt_q);
  assign reload_trig = trig && (mode == TM_RELOAD);

  always_comb begin
    cnt_nxt  = cnt_q;
    cap_nxt  = cap_q;
    ovf_set  = 1'b0;
    tick_nxt = 1'b0;
    if (step && !reload_trig) begin
      unique case (mode)
        TM_RELOAD: begin
          if (down) begin
            if (cnt_q == cap_q) begin
              cnt_nxt = ALL1;
              ovf_set = 1'b1;
            end else begin
              cnt_nxt = f_down(cnt_q);
            end
          end else if (up_v[CNT_W]) begin
            cnt_nxt = cap_q;
            ovf_set = 1'b1;
          end else begin
            cnt_nxt = up_v[CNT_W-1:0];
          end
        end
        TM_BAUD: begin
          if (up_v[CNT_W]) begin
            cnt_nxt  = cap_q;
            tick_nxt = 1'b1;
          end else begin
            cnt_nxt = up_v[CNT_W-1:0];
          end
        end
        default: begin
          cnt_nxt = up_v[CNT_W-1:0];
          ovf_set = up_v[CNT_W];
        end
      endcase
    end
    if (reload_trig) begin
      cnt_nxt = cap_q;
    end else if (trig && (mode == TM_CAPTURE || mode == TM_SPARE)) begin
      cap_nxt = cnt_q;
    end
    if (wr_cnt_lo) cnt_nxt[BYTE_W-1:0]     = wr_data;
    if (wr_cnt_hi) cnt_nxt[CNT_W-1:BYTE_W] = wr_data;
    if (wr_cap_lo) cap_nxt[BYTE_W-1:0]     = wr_data;
    if (wr_cap_hi) cap_nxt[CNT_W-1:BYTE_W] = wr_data;
  end

  assign ext_set = trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      cap_q  <= cap_nxt;
      tick_q <= tick_nxt;
    end
  end

  assign count = cnt_q;
  assign cap   = cap_q;
  assign tick  = tick_q;
endmodule

// File: rtl/tc16_capreload.sv
module tc16_capreload
  import tc16_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CYC_LEN = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_pin,
  input  logic                trig_pin,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] cap,
  output logic [BYTE_W-1:0]   ctrl_q,
  output logic [BYTE_W-1:0]   mode_q,
  output logic                ovf_flag,
  output logic                ext_flag,
  output logic                baud_tick
);
  localparam int NPIN = 2;

  logic            mc_en;
  logic [NPIN-1:0] pins, falls;
  logic            step, trig_evt, ovf_set, ext_set;
  logic            wr_ctrl, wr_mode;
  logic [BYTE_W-1:0] ctrl_r, mode_r;
  tc_mode_e        mode;

  assign pins = {trig_pin, cnt_pin};

  tc16_cycle_gen #(.CYC_LEN(CYC_LEN)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .mc_en (mc_en)
  );

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_samp
      tc16_fall_sampler u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .mc_en (mc_en),
        .pin   (pins[i]),
        .fall  (falls[i])
      );
    end
  endgenerate

  assign mode     = tc_mode_e'(ctrl_r[CB_MODE+1:CB_MODE]);
  assign step     = ctrl_r[CB_RUN] && (ctrl_r[CB_SRC] ? falls[0] : mc_en);
  assign trig_evt = ctrl_r[CB_TEN] && falls[1];
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_mode  = wr_en && (wr_addr == A_MODE);

  tc16_count_core #(.BYTE_W(BYTE_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .trig      (trig_evt),
    .mode      (mode),
    .down      (mode_r[MB_DOWN]),
    .wr_cnt_lo (wr_en && (wr_addr == A_CNT_LO)),
    .wr_cnt_hi (wr_en && (wr_addr == A_CNT_HI)),
    .wr_cap_lo (wr_en && (wr_addr == A_CAP_LO)),
    .wr_cap_hi (wr_en && (wr_addr == A_CAP_HI)),
    .wr_data   (wr_data),
    .count     (count),
    .cap       (cap),
    .ovf_set   (ovf_set),
    .ext_set   (ext_set),
    .tick      (baud_tick)
  );

  // hardware flag set takes priority over a software write of 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      mode_r <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_r <= wr_data;
        ctrl_r[CB_OVF] <= wr_data[CB_OVF] | ovf_set;
        ctrl_r[CB_EXT] <= wr_data[CB_EXT] | ext_set;
      end else begin
        ctrl_r[CB_OVF] <= ctrl_r[CB_OVF] | ovf_set;
        ctrl_r[CB_EXT] <= ctrl_r[CB_EXT] | ext_set;
      end
      if (wr_mode) mode_r[MB_DOWN] <= wr_data[MB_DOWN];
    end
  end

  assign ctrl_q   = ctrl_r;
  assign mode_q   = mode_r;
  assign ovf_flag = ctrl_r[CB_OVF];
  assign ext_flag = ctrl_r[CB_EXT];
endmodule

// File: rtl/tc16_capreload_chk.sv
module tc16_capreload_chk #(
  parameter int CNT_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cap,
  input logic [BYTE_W-1:0] ctrl_q,
  input logic              ovf_flag,
  input logic              ext_flag,
  input logic              baud_tick,
  input logic              mc_en,
  input logic              trig_evt,
  input logic              ovf_set
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (count == '0 && cap == '0 && !ovf_flag && !ext_flag && !baud_tick)); // R1

  AST_STEP_ON_CYCLE_END: assert property (@(posedge clk) disable iff (!rst_n) (!mc_en && !wr_en) |=> $stable(count)); // R2

  AST_RUN_GATES: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl_q[0] && !wr_en && !trig_evt) |=> $stable(count)); // R4

  AST_CAPTURE_COPIES: assert property (@(posedge clk) disable iff (!rst_n) (trig_evt && ctrl_q[4:3] == 2'd0 && !wr_en) |=> (cap == $past(count))); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) baud_tick |=> !baud_tick); // R11

  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[4:3] == 2'd2 && !wr_en) |=> !$rose(ovf_flag)); // R11

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) ovf_set |=> ovf_flag); // R12
endmodule

bind tc16_capreload tc16_capreload_chk #(.CNT_W(2*BYTE_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .count     (count),
  .cap       (cap),
  .ctrl_q    (ctrl_q),
  .ovf_flag  (ovf_flag),
  .ext_flag  (ext_flag),
  .baud_tick (baud_tick),
  .mc_en     (mc_en),
  .trig_evt  (trig_evt),
  .ovf_set   (ovf_set)
);

// File: tb/tc16_capreload_tb.sv
`timescale 1ns/1ps
module tc16_capreload_tb;
  localparam int MC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_pin = 1'b1;
  logic        trig_pin = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count, cap;
  logic [7:0]  ctrl_q, mode_q;
  logic        ovf_flag, ext_flag, baud_tick;

  int n_chk = 0;
  int n_fail = 0;
  int edge_n = 0;
  logic done = 1'b0;
  event mc_ev;

  tc16_capreload u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .cap(cap), .ctrl_q(ctrl_q), .mode_q(mode_q),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick)
  );

  always #5 clk = ~clk;

  // bench-side machine-cycle phase: the 12th clock after reset ends a cycle
  always @(posedge clk) begin
    if (rst_n) begin
      edge_n = edge_n + 1;
      if (edge_n % MC == 0) -> mc_ev;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_mc();
    @(mc_ev); #1;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  task automatic set_cap(input logic [15:0] v);
    wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 cap", cap, 0);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 flags/tick", {ovf_flag, ext_flag, baud_tick}, 0);
  endtask

  task automatic t_regs();
    wr(3'd1, 8'hFF);
    chk("R13 mode keeps bit0 only", mode_q, 8'h01);
    wr(3'd1, 8'h00);
    set_cap(16'hA55A);
    chk("R13 pair bytes", cap, 16'hA55A);
    set_cnt(16'h0000);
  endtask

  task automatic t_timer();
    logic [15:0] c;
    wr(3'd0, 8'h01);
    chk("R13 ctrl readback", ctrl_q, 8'h01);
    wait_mc();
    c = count;
    repeat (MC - 1) @(posedge clk);
    #1 chk("R2 stable inside cycle", count, c);
    @(posedge clk); #1;
    chk("R2 one step per cycle", count, c + 16'd1);
    wait_mc();
    chk("R2 second step", count, c + 16'd2);
  endtask

  task automatic t_stop();
    logic [15:0] c;
    wr(3'd0, 8'h00);
    c = count;
    repeat (3) wait_mc();
    chk("R4 held when stopped", count, c);
  endtask

  task automatic t_counter();
    set_cnt(16'h0000);
    wr(3'd0, 8'h03);
    wait_mc(); wait_mc();
    chk("R3 steady high no step", count, 0);
    cnt_pin = 1'b0;
    wait_mc();
    chk("R3 first fall", count, 1);
    wait_mc();
    chk("R3 steady low no step", count, 1);
    for (int i = 0; i < 3; i++) begin
      cnt_pin = 1'b1; wait_mc();
      cnt_pin = 1'b0; wait_mc();
    end
    chk("R3 four falls", count, 4);
    cnt_pin = 1'b1;
    wr(3'd0, 8'h00);
  endtask

  task automatic t_capture();
    logic [15:0] c;
    set_cnt(16'h1234);
    wr(3'd0, 8'h05);
    wait_mc();
    c = count;
    trig_pin = 1'b0;
    wait_mc();
    chk("R5 pair holds pre-step count", cap, c);
    chk("R5 count still stepped", count, c + 16'd1);
    chk("R5 external flag", ext_flag, 1);
    trig_pin = 1'b1;
    wr(3'd0, 8'h01);
    chk("R12 software clear ext", ext_flag, 0);
    wait_mc();
    trig_pin = 1'b0;
    wait_mc();
    chk("R6 pair unchanged", cap, c);
    chk("R6 no external flag", ext_flag, 0);
    trig_pin = 1'b1;
  endtask

  task automatic t_wrap();
    wr(3'd0, 8'h00);
    set_cnt(16'hFFFE);
    wr(3'd0, 8'h01);
    wait_mc();
    chk("R7 to FFFF no flag", {ovf_flag, count}, {1'b0, 16'hFFFF});
    wait_mc();
    chk("R7 wrap to zero", count, 16'h0000);
    chk("R7 overflow flag", ovf_flag, 1);
    wr(3'd0, 8'h01);
    chk("R12 software clear ovf", ovf_flag, 0);
  endtask

  task automatic t_collide();
    wr(3'd0, 8'h00);
    set_cnt(16'hFFFF);
    wr(3'd0, 8'h01);
    while (1) begin
      @(negedge clk);
      if (edge_n % MC == MC - 1) break;
    end
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h01;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R12 set wins over clear", ovf_flag, 1);
    chk("R12 count wrapped", count, 16'h0000);
  endtask

  task automatic t_reload_up();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    set_cap(16'hFF00);
    set_cnt(16'hFFFF);
    wr(3'd0, 8'h09);
    wait_mc();
    chk("R8 reload from pair", count, 16'hFF00);
    chk("R8 overflow flag", ovf_flag, 1);
    wait_mc();
    chk("R8 continues up", count, 16'hFF01);
  endtask

  task automatic t_reload_down();
    wr(3'd0, 8'h00);
    set_cap(16'h0010);
    set_cnt(16'h0012);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h09);
    wait_mc();
    wait_mc();
    chk("R9 down to pair no flag", {ovf_flag, count}, {1'b0, 16'h0010});
    wait_mc();
    chk("R9 underflow to FFFF", count, 16'hFFFF);
    chk("R9 underflow flag", ovf_flag, 1);
    wait_mc();
    chk("R9 continues down", count, 16'hFFFE);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_reload_trig();
    wr(3'd0, 8'h00);
    set_cap(16'h0100);
    set_cnt(16'h5000);
    wr(3'd0, 8'h0D);
    wait_mc();
    trig_pin = 1'b0;
    wait_mc();
    chk("R10 trigger reloads, step lost", count, 16'h0100);
    chk("R10 external flag", ext_flag, 1);
    trig_pin = 1'b1;
  endtask

  task automatic t_baud();
    wr(3'd0, 8'h00);
    set_cap(16'hFFFD);
    set_cnt(16'hFFFE);
    wr(3'd0, 8'h11);
    wait_mc();
    chk("R11 no tick before wrap", {baud_tick, count}, {1'b0, 16'hFFFF});
    wait_mc();
    chk("R11 reload and tick", {baud_tick, count}, {1'b1, 16'hFFFD});
    chk("R11 no overflow flag", ovf_flag, 0);
    @(posedge clk); #1;
    chk("R11 tick one clock", baud_tick, 0);
    wait_mc(); wait_mc(); wait_mc();
    chk("R11 period of three cycles", {baud_tick, count}, {1'b1, 16'hFFFD});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_regs();
    t_timer();
    t_stop();
    t_counter();
    t_capture();
    t_wrap();
    t_collide();
    t_reload_up();
    t_reload_down();
    t_reload_trig();
    t_baud();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule